// File: doc/BRIEF.md
# CAN Intermission and Frame-Start Sequencer

This block is the bit-level sequencer that a CAN protocol controller runs between frames. It works only on a one-cycle sample-point strobe that bit timing logic outside the block supplies. On each strobe it uses the sampled bus level and a transmit-pending flag to follow bus integration after reset, the idle bus, and the three intermission bits that follow each frame's end. It then decides whether a dominant level marks a start of frame, either from another node or early on the third intermission bit.

When a transmission starts, the block loads a header image into its shift register. The image is built from the pending message's identifier, format flag, remote flag and DLC, which are read at the same strobe that decides the start. The block shifts this image out MSB first and watches for arbitration loss. A transmission that starts early, on a dominant third intermission bit, also sends the requested message's own fields, and it skips its own start-of-frame bit. After an arbitration loss or a bus error the block drops the transmission and pulses a retry flag. The next start reloads the header from the live inputs. Bit stuffing, CRC, the data field and error frames are handled by the surrounding controller.

Top module: `can_ifs_seq`

## Requirements
- R1: While reset is held and after it is released, activity reads 2'b00 (synchronizing), tx_bit is 1 (recessive), and arb_lost, hdr_done and tx_retry are 0.
- R2: In the synchronizing state, IDLE_BITS (default 11) consecutive recessive samples move activity to 2'b01 (idle). A dominant sample restarts the count.
- R3: State and outputs change only on clocks where sp_strobe is 1. Bus level changes between strobes have no effect.
- R4: In idle with tx_pend low, a dominant sample moves activity to 2'b10 (receiver).
- R5: In idle with tx_pend high and a recessive sample, activity becomes 2'b11 (transmitter). tx_bit drives one dominant start-of-frame bit, then the header bits MSB first.
- R6: A strobe with frame_end high in the receiver state, or in the transmitter state after the header, starts intermission. The first two intermission samples cause no state change. A recessive third sample with tx_pend low returns activity to idle.
- R7: A dominant third intermission sample with tx_pend high counts as start of frame. This holds even when tx_pend rose during intermission. Activity becomes 2'b11 and the next bit drives the first header bit, with no start-of-frame bit of its own.
- R8: With tx_ext=0 the header is 18 bits: id[10:0], rtr, 0, 0, dlc[3:0]. With tx_ext=1 it is 38 bits: id[28:18], 1, 1, id[17:0], rtr, 0, 0, dlc[3:0]. The fields are taken from the inputs at the strobe that starts the frame.
- R9: A recessive tx_bit sampled dominant inside the arbitration window causes a one-cycle arb_lost and tx_retry pulse, activity 2'b10 and tx_bit 1. The window is the first 13 header bits in base format and the first 32 in extended format.
- R10: A recessive tx_bit sampled dominant after the arbitration window causes no arbitration loss, and transmission continues.
- R11: bus_err on a strobe while transmitting causes a one-cycle tx_retry pulse, activity 2'b10 and tx_bit 1. The next start reloads the header from the current inputs.
- R12: The strobe that sends the last header bit causes a one-cycle hdr_done pulse, and tx_bit then stays recessive.
- R13: A dominant third intermission sample with tx_pend low moves activity to the receiver state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sp_strobe | input | 1 | One-cycle sample-point strobe |
| rx_bit | input | 1 | Sampled bus level, 0 dominant |
| tx_pend | input | 1 | A message waits for transmission |
| tx_ext | input | 1 | Pending message uses the 29-bit identifier |
| tx_rtr | input | 1 | Pending message remote flag |
| tx_id | input | 29 | Pending message identifier, base format uses [10:0] |
| tx_dlc | input | 4 | Pending message data length code |
| frame_end | input | 1 | With a strobe: last end-of-frame bit sampled |
| bus_err | input | 1 | With a strobe: bus error detected |
| tx_bit | output | 1 | Level to drive on the bus, 0 dominant |
| act | output | 2 | Activity: 00 sync, 01 idle, 10 receiver, 11 transmitter |
| arb_lost | output | 1 | One-cycle arbitration-loss pulse |
| hdr_done | output | 1 | One-cycle pulse after the last header bit |
| tx_retry | output | 1 | One-cycle pulse: message must be sent again |

## Verification
The main corner case is a request raised in mid-intermission followed by a dominant third bit. A design that skips the header load there would send stale or zero fields, and one that inserts its own start bit would be one bit late. The bench compares the full serialized header, in both formats, with an image built from the requirement. It also drives a dominant level against a recessive control-field bit: a design with the wrong arbitration window would report a loss there. After an arbitration loss and a bus error, the bench changes the message fields and checks that the retried frame carries the new ones, not the ones left in the register.

// File: rtl/ifs_pkg.sv
// Shared types and sizes for the intermission and frame-start sequencer.
// Assumes the classic CAN header layout without stuffing.
package ifs_pkg;
    localparam int ID_W     = 29;
    localparam int DLC_W    = 4;
    localparam int BASE_HDR = 18;
    localparam int EXT_HDR  = 38;
    localparam int BASE_ARB = 13;
    localparam int EXT_ARB  = 32;
    localparam int HIX_W    = $clog2(EXT_HDR + 1);

    typedef enum logic [1:0] {
        ACT_SYNC = 2'b00,
        ACT_IDLE = 2'b01,
        ACT_RECV = 2'b10,
        ACT_XMIT = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        PH_SOF  = 2'b00,
        PH_HDR  = 2'b01,
        PH_BODY = 2'b10
    } ph_e;
endpackage

// File: rtl/ifs_sync_cnt.sv
// Counts consecutive recessive samples for bus integration.
// Assumes one sample per sp strobe. The count saturates at IDLE_BITS.
module ifs_sync_cnt #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sp,
    input  logic rx,
    output logic hit
);
    localparam int CW = $clog2(IDLE_BITS + 1);

    logic [CW-1:0] cnt_q;

    // Count recessive samples and restart on a dominant one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sp) begin
            if (!rx) begin
                cnt_q <= '0;
            end else if (cnt_q != CW'(IDLE_BITS)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // The sample that completes the run of recessive bits.
    assign hit = sp && rx && (cnt_q >= CW'(IDLE_BITS - 1));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(IDLE_BITS));
endmodule

// File: rtl/ifs_hdr_shift.sv
// Header shift register: builds the arbitration and control image from the
// message fields on load and shifts it out MSB first.
// Assumes load and shift are never high together.
module ifs_hdr_shift
    import ifs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             ext,
    input  logic [ID_W-1:0]  id,
    input  logic             rtr,
    input  logic [DLC_W-1:0] dlc,
    output logic             cur_bit,
    output logic             in_arb,
    output logic             last
);
    logic [EXT_HDR-1:0] sr_q;
    logic [EXT_HDR-1:0] img;
    logic [HIX_W-1:0]   idx_q;
    logic [HIX_W-1:0]   len_q;
    logic [HIX_W-1:0]   arb_q;

    // Build the left-aligned header image for the chosen format.
    always_comb begin
        if (ext) begin
            img = {id[28:18], 1'b1, 1'b1, id[17:0], rtr, 1'b0, 1'b0, dlc};
        end else begin
            img = {id[10:0], rtr, 1'b0, 1'b0, dlc, {(EXT_HDR - BASE_HDR){1'b0}}};
        end
    end

    // Load a fresh image or move one bit further.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '1;
            idx_q <= '0;
            len_q <= HIX_W'(BASE_HDR);
            arb_q <= HIX_W'(BASE_ARB);
        end else if (load) begin
            sr_q  <= img;
            idx_q <= '0;
            len_q <= ext ? HIX_W'(EXT_HDR) : HIX_W'(BASE_HDR);
            arb_q <= ext ? HIX_W'(EXT_ARB) : HIX_W'(BASE_ARB);
        end else if (shift) begin
            sr_q  <= {sr_q[EXT_HDR-2:0], 1'b1};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign cur_bit = sr_q[EXT_HDR-1];
    assign in_arb  = idx_q < arb_q;
    assign last    = idx_q == (len_q - 1'b1);

    p_idx_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= len_q);
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/ifs_fsm.sv
// Sequencer control: bus integration, idle, receive, transmit and the
// three intermission bits, including the start-of-frame decision.
// Assumes every input is meaningful only on a cycle with sp high.
module ifs_fsm
    import ifs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sp,
    input  logic rx,
    input  logic pend,
    input  logic fdone,
    input  logic berr,
    input  logic sync_hit,
    input  logic cur_bit,
    input  logic in_arb,
    input  logic last,
    output logic load,
    output logic shift,
    output act_e act,
    output logic tx_bit,
    output logic arb_lost,
    output logic hdr_done,
    output logic retry
);
    act_e       state_q, st_d;
    ph_e        ph_q, ph_d;
    logic       in_ifs_q, ifs_d;
    logic [1:0] pos_q, pos_d;
    logic       lost_d, done_d, retry_d;
    logic       decide;

    // Next-state logic, evaluated only on a sample point.
    always_comb begin
        st_d    = state_q;
        ph_d    = ph_q;
        ifs_d   = in_ifs_q;
        pos_d   = pos_q;
        load    = 1'b0;
        shift   = 1'b0;
        lost_d  = 1'b0;
        done_d  = 1'b0;
        retry_d = 1'b0;
        decide  = (in_ifs_q && pos_q == 2'd2) || (!in_ifs_q && state_q == ACT_IDLE);
        if (sp) begin
            if (decide) begin
                ifs_d = 1'b0;
                if (pend) begin
                    load = 1'b1;
                    st_d = ACT_XMIT;
                    ph_d = rx ? PH_SOF : PH_HDR;
                end else if (!rx) begin
                    st_d = ACT_RECV;
                    ph_d = PH_BODY;
                end else begin
                    st_d = ACT_IDLE;
                    ph_d = PH_BODY;
                end
            end else if (in_ifs_q) begin
                pos_d = pos_q + 2'd1;
            end else begin
                case (state_q)
                    ACT_SYNC: begin
                        if (sync_hit) begin
                            st_d = ACT_IDLE;
                        end
                    end
                    ACT_RECV: begin
                        if (fdone) begin
                            ifs_d = 1'b1;
                            pos_d = 2'd0;
                        end
                    end
                    ACT_XMIT: begin
                        if (berr) begin
                            retry_d = 1'b1;
                            st_d    = ACT_RECV;
                            ph_d    = PH_BODY;
                        end else begin
                            case (ph_q)
                                PH_SOF: ph_d = PH_HDR;
                                PH_HDR: begin
                                    if (in_arb && cur_bit && !rx) begin
                                        lost_d  = 1'b1;
                                        retry_d = 1'b1;
                                        st_d    = ACT_RECV;
                                        ph_d    = PH_BODY;
                                    end else begin
                                        shift = 1'b1;
                                        if (last) begin
                                            done_d = 1'b1;
                                            ph_d   = PH_BODY;
                                        end
                                    end
                                end
                                default: begin
                                    if (fdone) begin
                                        ifs_d = 1'b1;
                                        pos_d = 2'd0;
                                    end
                                end
                            endcase
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // State registers and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ACT_SYNC;
            ph_q     <= PH_BODY;
            in_ifs_q <= 1'b0;
            pos_q    <= 2'd0;
            arb_lost <= 1'b0;
            hdr_done <= 1'b0;
            retry    <= 1'b0;
        end else begin
            state_q  <= st_d;
            ph_q     <= ph_d;
            in_ifs_q <= ifs_d;
            pos_q    <= pos_d;
            arb_lost <= lost_d;
            hdr_done <= done_d;
            retry    <= retry_d;
        end
    end

    assign act    = state_q;
    // Drive the start bit, then header bits, else stay recessive.
    assign tx_bit = (state_q != ACT_XMIT) ? 1'b1 :
                    (ph_q == PH_SOF)      ? 1'b0 :
                    (ph_q == PH_HDR)      ? cur_bit : 1'b1;

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sp |=> $stable(state_q) && $stable(ph_q));
    p_idle_recv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACT_IDLE && sp && !rx && !pend) |=> state_q == ACT_RECV);
    p_early_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ifs_q && pos_q == 2'd2 && sp && !rx && pend)
        |=> (state_q == ACT_XMIT && ph_q == PH_HDR));
    p_lost_recv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (state_q == ACT_RECV && retry));
    p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |-> tx_bit);
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arb_lost, hdr_done}));
endmodule

// File: rtl/can_ifs_seq.sv
// Top of the intermission and frame-start sequencer. Joins bus integration,
// control and the header shift register.
// Assumes the sample strobe and the bus sample come from bit timing logic.
module can_ifs_seq
    import ifs_pkg::*;
#(
    parameter int IDLE_BITS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sp_strobe,
    input  logic             rx_bit,
    input  logic             tx_pend,
    input  logic             tx_ext,
    input  logic             tx_rtr,
    input  logic [ID_W-1:0]  tx_id,
    input  logic [DLC_W-1:0] tx_dlc,
    input  logic             frame_end,
    input  logic             bus_err,
    output logic             tx_bit,
    output logic [1:0]       act,
    output logic             arb_lost,
    output logic             hdr_done,
    output logic             tx_retry
);
    logic sync_hit, load, shift, cur_bit, in_arb, last;
    act_e act_w;

    ifs_sync_cnt #(.IDLE_BITS(IDLE_BITS)) u_sync (
        .clk(clk), .rst_n(rst_n), .sp(sp_strobe), .rx(rx_bit), .hit(sync_hit)
    );

    ifs_hdr_shift u_hdr (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .ext(tx_ext), .id(tx_id), .rtr(tx_rtr), .dlc(tx_dlc),
        .cur_bit(cur_bit), .in_arb(in_arb), .last(last)
    );

    ifs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sp(sp_strobe), .rx(rx_bit), .pend(tx_pend),
        .fdone(frame_end), .berr(bus_err), .sync_hit(sync_hit),
        .cur_bit(cur_bit), .in_arb(in_arb), .last(last),
        .load(load), .shift(shift), .act(act_w), .tx_bit(tx_bit),
        .arb_lost(arb_lost), .hdr_done(hdr_done), .retry(tx_retry)
    );

    assign act = act_w;

    p_lost_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> ($past(tx_bit) && !$past(rx_bit) && $past(sp_strobe)));
    p_retry_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_retry |-> ($past(act) == 2'b11 && $past(sp_strobe)));
endmodule

// File: tb/can_ifs_seq_bench.sv
module can_ifs_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sp = 1'b0, rx = 1'b1, pend = 1'b0, ext = 1'b0, rtr = 1'b0;
    logic        fd = 1'b0, be = 1'b0;
    logic [28:0] id = '0;
    logic [3:0]  dlc = '0;
    logic        txb, lost, hdone, retry;
    logic [1:0]  act;
    logic        s_tx, s_lost, s_done, s_retry;
    logic [1:0]  s_act;
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    can_ifs_seq u_can_ifs_seq (
        .clk(clk), .rst_n(rst_n), .sp_strobe(sp), .rx_bit(rx), .tx_pend(pend),
        .tx_ext(ext), .tx_rtr(rtr), .tx_id(id), .tx_dlc(dlc),
        .frame_end(fd), .bus_err(be), .tx_bit(txb), .act(act),
        .arb_lost(lost), .hdr_done(hdone), .tx_retry(retry)
    );

    // rx, pend, frame_end, expected act, expected tx_bit
    localparam logic [5:0] VEC [11] = '{
        6'b0_0_0_10_1, 6'b1_0_0_10_1, 6'b0_0_1_10_1, 6'b1_0_0_10_1,
        6'b0_0_0_10_1, 6'b0_0_0_10_1, 6'b1_0_1_10_1, 6'b1_0_0_10_1,
        6'b1_0_0_10_1, 6'b1_0_0_01_1, 6'b1_0_0_01_1
    };

    function automatic logic [37:0] want(input logic e, input logic [28:0] i,
                                         input logic r, input logic [3:0] d);
        logic [37:0] v;
        if (e) v = {i[28:18], 2'b11, i[17:0], r, 2'b00, d};
        else   v = {i[10:0], r, 2'b00, d, 20'd0};
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(input logic b, input logic f, input logic e);
        @(negedge clk);
        rx = b; fd = f; be = e; sp = 1'b1;
        @(negedge clk);
        sp = 1'b0; fd = 1'b0; be = 1'b0;
        s_act = act; s_tx = txb; s_lost = lost; s_done = hdone; s_retry = retry;
        repeat (2) @(negedge clk);
    endtask

    task automatic to_idle();
        step(1'b1, 1'b1, 1'b0);
        repeat (3) step(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [37:0] cap, exp;
        logic        seen;
        repeat (3) @(negedge clk);
        chk("R1 act in reset", act, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 act after reset", act, 2'b00);
        chk("R1 tx and pulses", {txb, lost, hdone, retry}, 4'b1000);

        // R2: a dominant bit restarts integration
        repeat (5) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        repeat (10) step(1'b1, 1'b0, 1'b0);
        chk("R2 ten recessive after dominant", s_act, 2'b00);
        step(1'b1, 1'b0, 1'b0);
        chk("R2 eleventh recessive", s_act, 2'b01);

        // R4 R6 R13 receive and intermission table
        for (int i = 0; i < 11; i++) begin
            pend = VEC[i][4];
            step(VEC[i][5], VEC[i][3], 1'b0);
            chk("R4 R6 R13 table act", s_act, VEC[i][2:1]);
            chk("R4 R6 R13 table tx", s_tx, VEC[i][0]);
        end

        // R3: bus activity without a strobe is ignored
        rx = 1'b0;
        repeat (8) @(negedge clk);
        chk("R3 no strobe keeps idle", {act, txb}, 3'b011);
        rx = 1'b1;

        // R5 R8 R10 R12: own start bit, base header, dominant in control field
        ext = 1'b0; id = 29'h5A3; rtr = 1'b0; dlc = 4'hF; pend = 1'b1;
        exp = want(ext, id, rtr, dlc);
        step(1'b1, 1'b0, 1'b0);
        chk("R5 start bit", {s_act, s_tx}, 3'b110);
        step(1'b0, 1'b0, 1'b0);
        seen = 1'b0; cap = '0;
        for (int i = 0; i < 18; i++) begin
            cap[37 - i] = s_tx;
            step((i == 15) ? 1'b0 : s_tx, 1'b0, 1'b0);
            seen = seen | s_lost;
        end
        chk("R8 base header", cap, exp);
        chk("R10 no loss outside window", {seen, s_act}, 3'b011);
        chk("R12 header done", {s_done, s_tx}, 2'b11);
        pend = 1'b0;
        to_idle();
        chk("R6 back to idle", s_act, 2'b01);

        // R7 R8: late request with dominant third intermission bit
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        ext = 1'b1; id = 29'h0B5A_3C71; rtr = 1'b1; dlc = 4'h6; pend = 1'b1;
        exp = want(ext, id, rtr, dlc);
        step(1'b1, 1'b0, 1'b0);
        chk("R7 still receiver at second bit", s_act, 2'b10);
        step(1'b0, 1'b0, 1'b0);
        chk("R7 early start first header bit", {s_act, s_tx}, {2'b11, exp[37]});
        cap = '0;
        for (int i = 0; i < 38; i++) begin
            cap[37 - i] = s_tx;
            step(s_tx, 1'b0, 1'b0);
        end
        chk("R7 R8 extended header", cap, exp);
        chk("R12 extended done", s_done, 1'b1);
        pend = 1'b0;
        to_idle();

        // R9: arbitration loss on the first identifier bit
        ext = 1'b0; id = 29'h7FF; rtr = 1'b0; dlc = 4'h2; pend = 1'b1;
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R9 loss pulses", {s_lost, s_retry}, 2'b11);
        chk("R9 receiver recessive", {s_act, s_tx}, 3'b101);

        // R11: bus error then reload with new fields
        step(1'b1, 1'b1, 1'b0);
        id = 29'h123; dlc = 4'h3;
        exp = want(ext, id, rtr, dlc);
        repeat (3) step(1'b1, 1'b0, 1'b0);
        chk("R5 start bit after intermission", {s_act, s_tx}, 3'b110);
        step(1'b0, 1'b0, 1'b0);
        repeat (3) step(s_tx, 1'b0, 1'b0);
        step(s_tx, 1'b0, 1'b1);
        chk("R11 error drops transmission", {s_retry, s_act, s_tx, s_lost}, 5'b11010);
        to_idle();
        step(1'b0, 1'b0, 1'b0);
        cap = '0;
        for (int i = 0; i < 18; i++) begin
            cap[37 - i] = s_tx;
            step(s_tx, 1'b0, 1'b0);
        end
        chk("R11 retried header uses new fields", cap, exp);
        pend = 1'b0;
        to_idle();
        chk("R6 idle at end", s_act, 2'b01);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule